// File: doc/BRIEF.md
# Host DMA Request Handshake Generator

This block raises a request line toward an external DMA controller for an on-chip processor. The processor writes one configuration word. It holds a request-arm bit, an output-polarity bit and an operating-mode bit. While the mode bit is 0, writing the arm bit as 1 makes a request pending. The request pin then shows the active level straight away, and the level follows the polarity bit.

The host sends two asynchronous strobes to acknowledge the request: an active-low chip select and an active-low register select. Each strobe is re-timed into the peripheral clock by its own two-flop synchronizer. The first synchronized cycle in which both strobes are low counts as the acknowledge. It drops the request, and the pending bit clears on the same clock edge that returns the pin to its inactive level.

Only the level-mode handshake is built here. A write with the mode bit set to 1 stores the polarity but never arms a request.

Top module: `host_dreq_gen`

## Requirements
- R1: After reset the pending bit (`req_pending`) is 0, the stored polarity is 0 and the stored mode is 0, so `dreq_pin` is 1.
- R2: A write (`cfg_we`=1) with `cfg_wdata[0]`=1 and `cfg_wdata[2]`=0 sets `req_pending` on the clock edge that takes the write.
- R3: `req_pending` and the active pin level are withdrawn on the same clock edge.
- R4: Every write stores `cfg_wdata[1]` as the polarity. With polarity 0 a pending request drives `dreq_pin` low, and with polarity 1 it drives `dreq_pin` high. The inactive level is the opposite one.
- R5: If both strobes go low between two clock edges and stay low, the request is withdrawn on the third following edge, and not before.
- R6: A write with `cfg_wdata[0]`=0 leaves `req_pending` unchanged. A write of 1 while a request is pending keeps it pending.
- R7: Only a synchronized cycle with both strobes low acknowledges. Chip select low alone, or register select low alone, leaves the request pending for any length of time.
- R8: Writing polarity 1 while no request is pending moves `dreq_pin` low on the edge that takes the write.
- R9: If an arming write and an acknowledge meet in one cycle, a request that was already pending is cleared, while a request that was not yet pending is set.
- R10: A write with `cfg_wdata[2]`=1 never sets `req_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe from the CPU |
| cfg_wdata | input | 3 | Write data: bit 0 arm, bit 1 polarity, bit 2 mode |
| host_cs_n | input | 1 | Asynchronous host chip select, active low |
| host_rs_n | input | 1 | Asynchronous host register select, active low |
| dreq_pin | output | 1 | Request line toward the DMA controller |
| req_pending | output | 1 | Readable state of the pending request bit |

## Verification
Because the pin is decoded from the pending bit and the stored polarity, a wrong pending bit appears on `dreq_pin` in the same cycle. A wrong stored polarity shows on the pin at once in either state. A synchronizer that is too short or too long moves the withdrawal edge one cycle earlier or later than the third edge after both strobes fall, so every acknowledge is checked at exactly that edge. A decode that treats a single low strobe as an acknowledge drops a request that ought to stay pending, and a wrong priority shows up in the coincident write-and-acknowledge cycle.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  localparam int CFG_W    = 3;
  localparam int BIT_ARM  = 0;
  localparam int BIT_POL  = 1;
  localparam int BIT_MODE = 2;

  typedef struct packed {
    logic mode;
    logic pol;
  } hdr_cfg_t;

  // Pin level for a given polarity and pending state.
  function automatic logic pin_level(input logic pol, input logic pend);
    return pend ? pol : ~pol;
  endfunction

  // Next pending state: a pending request yields to the acknowledge,
  // an idle one takes a new arm request.
  function automatic logic next_pending(input logic pend, input logic ack,
                                        input logic arm);
    return pend ? ~ack : arm;
  endfunction

endpackage

// File: rtl/hdr_sync.sv
module hdr_sync #(
  parameter int N_SIG  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] async_in,
  output logic [N_SIG-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else if (STAGES == 1) chain <= async_in[s];
      else chain <= {chain[STAGES-2:0], async_in[s]};
    end
    assign sync_out[s] = chain[LAST];
  end

endmodule

// File: rtl/hdr_req_core.sv
module hdr_req_core
  import hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ack,
  output logic             arm_req,
  output logic             pend_q,
  output hdr_cfg_t         cfg_q
);

  assign arm_req = cfg_we & cfg_wdata[BIT_ARM] & ~cfg_wdata[BIT_MODE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      pend_q <= next_pending(pend_q, ack, arm_req);
      if (cfg_we) begin
        cfg_q.pol  <= cfg_wdata[BIT_POL];
        cfg_q.mode <= cfg_wdata[BIT_MODE];
      end
    end
  end

endmodule

// File: rtl/hdr_pin_drv.sv
module hdr_pin_drv
  import hdr_pkg::*;
(
  input  logic pol,
  input  logic pend,
  output logic pin
);

  always_comb pin = pin_level(pol, pend);

endmodule

// File: rtl/host_dreq_gen.sv
module host_dreq_gen
  import hdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             host_cs_n,
  input  logic             host_rs_n,
  output logic             dreq_pin,
  output logic             req_pending
);

  localparam int N_STROBE = 2;

  logic [N_STROBE-1:0] strobe_sync;
  logic                ack_seen;
  logic                arm_req;
  logic                pend_q;
  hdr_cfg_t            cfg_q;

  hdr_sync #(.N_SIG(N_STROBE), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({host_rs_n, host_cs_n}),
    .sync_out (strobe_sync)
  );

  // Acknowledge event: both synchronized strobes low in one cycle.
  assign ack_seen = ~|strobe_sync;

  hdr_req_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .ack       (ack_seen),
    .arm_req   (arm_req),
    .pend_q    (pend_q),
    .cfg_q     (cfg_q)
  );

  hdr_pin_drv u_pin (
    .pol  (cfg_q.pol),
    .pend (pend_q),
    .pin  (dreq_pin)
  );

  assign req_pending = pend_q;

endmodule

// File: rtl/host_dreq_gen_chk.sv
module host_dreq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_wdata,
  input logic       ack_seen,
  input logic       arm_req,
  input logic       pend_q,
  input logic       pol_q,
  input logic       dreq_pin
);

  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && arm_req) |=> pend_q);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack_seen) |=> !pend_q);

  p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_seen) |=> pend_q);

  p_mode1_no_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && cfg_we && cfg_wdata[2]) |=> !pend_q);

  p_pol_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && cfg_we && cfg_wdata[1] && !arm_req) |=> !dreq_pin);

endmodule

bind host_dreq_gen host_dreq_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .ack_seen  (ack_seen),
  .arm_req   (arm_req),
  .pend_q    (pend_q),
  .pol_q     (cfg_q.pol),
  .dreq_pin  (dreq_pin)
);

// File: tb/host_dreq_gen_tb.sv
module host_dreq_gen_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  typedef struct {
    logic  pin;
    logic  pend;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       host_cs_n = 1'b1;
  logic       host_rs_n = 1'b1;
  logic       dreq_pin;
  logic       req_pending;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_dreq_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .host_cs_n   (host_cs_n),
    .host_rs_n   (host_rs_n),
    .dreq_pin    (dreq_pin),
    .req_pending (req_pending)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (dreq_pin !== e.pin || req_pending !== e.pend) begin
      errors++;
      $display("FAIL %s: pin=%b pend=%b expected pin=%b pend=%b",
               e.tag, dreq_pin, req_pending, e.pin, e.pend);
    end
  endtask

  // Monitor: one edge after each driven cycle, compare queued items.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  // Driver: apply inputs for one cycle and queue the expected result.
  task automatic cyc(input logic we, input logic [2:0] d, input logic cs,
                     input logic rs, input logic e_pin, input logic e_pend,
                     input string tag);
    exp_t e;
    @(negedge clk);
    #2;
    cfg_we    = we;
    cfg_wdata = d;
    host_cs_n = cs;
    host_rs_n = rs;
    e.pin  = e_pin;
    e.pend = e_pend;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    r.pin = 1'b1; r.pend = 1'b0; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1'b1;
    cyc(0, 3'b000, 1, 1, 1, 0, "R1 idle after reset");

    // Arm with polarity 0: active low.
    cyc(1, 3'b001, 1, 1, 0, 1, "R2 arm sets pending, R4 active low");
    cyc(0, 3'b000, 1, 1, 0, 1, "R6 held pending");
    cyc(1, 3'b000, 1, 1, 0, 1, "R6 write of zero ignored");

    // Single strobe low does not acknowledge.
    for (int i = 0; i < 5; i++) cyc(0, 3'b000, 0, 1, 0, 1, "R7 chip select alone");
    cyc(0, 3'b000, 1, 1, 0, 1, "R7 strobes released");
    for (int i = 0; i < 5; i++) cyc(0, 3'b000, 1, 0, 0, 1, "R7 register select alone");
    cyc(0, 3'b000, 1, 1, 0, 1, "R7 strobes released");
    cyc(0, 3'b000, 1, 1, 0, 1, "R7 still pending");

    // Acknowledge: withdrawn on the third edge.
    cyc(0, 3'b000, 0, 0, 0, 1, "R5 edge 1 still pending");
    cyc(0, 3'b000, 0, 0, 0, 1, "R5 edge 2 still pending");
    cyc(0, 3'b000, 0, 0, 1, 0, "R5 R3 edge 3 withdrawn, pin inactive");
    cyc(0, 3'b000, 1, 1, 1, 0, "R3 stays idle");
    cyc(0, 3'b000, 1, 1, 1, 0, "R3 stays idle");
    cyc(0, 3'b000, 1, 1, 1, 0, "R3 stays idle");

    // Polarity 1.
    cyc(1, 3'b010, 1, 1, 0, 0, "R8 polarity write drives pin low");
    cyc(1, 3'b011, 1, 1, 1, 1, "R4 active high request");
    cyc(1, 3'b011, 1, 1, 1, 1, "R6 rearm while pending");

    // Coincident arm and acknowledge.
    cyc(0, 3'b010, 0, 0, 1, 1, "R9 edge 1");
    cyc(0, 3'b010, 0, 0, 1, 1, "R9 edge 2");
    cyc(1, 3'b011, 0, 0, 0, 0, "R9 ack beats arm when pending");
    cyc(1, 3'b011, 0, 0, 1, 1, "R9 arm beats ack when idle");
    cyc(0, 3'b010, 0, 0, 0, 0, "R9 held strobes clear again");
    cyc(0, 3'b010, 1, 1, 0, 0, "R9 release");
    cyc(0, 3'b010, 1, 1, 0, 0, "R9 release");
    cyc(0, 3'b010, 1, 1, 0, 0, "R9 release");

    // Mode 1 never arms.
    cyc(1, 3'b111, 1, 1, 0, 0, "R10 mode 1 arm ignored");
    cyc(0, 3'b000, 1, 1, 0, 0, "R10 still idle");
    cyc(1, 3'b011, 1, 1, 1, 1, "R2 mode 0 arm again");
    cyc(0, 3'b000, 1, 1, 1, 1, "R4 pending, polarity held");

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule